// File: doc/BRIEF.md
# Framer Interrupt Hub With Re-Trigger Guard

This block gathers interrupt events from the receive and transmit sections of a DS3/E3 framer. Each source has a status register and an enable register of the same width. An event bit is latched only when its enable bit is set. Reading a status register returns the pending bits and clears them. The source registers roll up into a block-level summary that has one bit for the receive section and one for the transmit section. That summary drives a registered, active-low interrupt request.

There are six source slots. Slot 0 is receive status A, slot 1 receive status B, slot 2 receive far-end alarm code, slot 3 receive datalink, slot 4 transmit far-end alarm code and slot 5 transmit datalink. The `e3_mode` input selects the address map. In DS3 mode slot 1 is absent. In E3 mode slots 2 and 4 are absent.

Each slot has a small guard state machine that protects against interrupt storms. Its states are QUIET, COUNTING and TRIPPED. A read that finds the status nonzero is a service. A read that finds it zero is a quiet read.
- QUIET goes to COUNTING on a service.
- COUNTING goes back to QUIET on a quiet read.
- COUNTING goes to TRIPPED on the STORM_N-th consecutive service. On that same edge the slot's enable register is cleared and a sticky storm flag is set.
- TRIPPED goes to QUIET when software writes the enable register.

Top module: `irq_hub`

## Requirements
- R1: After reset, `irq_n` is 1, `rd_data` is 0, and every status, enable, summary and storm-flag register reads 0.
- R2: A status bit is set only on a clock edge where both its event bit and its enable bit are 1. Events on disabled bits leave the status unchanged.
- R3: A read of a status register returns the register's value on `rd_data` one cycle later and clears the register on the read edge. A second read then returns 0.
- R4: If an enabled event and a read of the same status register fall on the same edge, the read returns the old value and the new event bits remain set.
- R5: The summary register at 0x10 has bit 0 equal to the OR of all receive slots (0 to 3) and bit 1 equal to the OR of the transmit slots (4 and 5). A summary bit reads 0 once the last pending slot in its section has been read.
- R6: `irq_n` goes low one cycle after any status bit is set. It goes high one cycle after no status bit remains. An event that recurs after service drives `irq_n` low again.
- R7: Each enable register sits at its status address plus 0x40. Its low SRC_W bits are read/write.
- R8: On the STORM_N-th consecutive service read of a slot (default 4), that slot's enable is cleared and storm flag bit s (slot index) is set at address 0x12. A quiet read in between restarts the count. Reading 0x12 clears the flags. Writing the enable re-arms the slot.
- R9: In DS3 mode (`e3_mode`=0) the status addresses are 0x13 (slot 0), 0x17 (slot 2), 0x18 (slot 3), 0x31 (slot 4) and 0x34 (slot 5).
- R10: In E3 mode (`e3_mode`=1) the status addresses are 0x14 (slot 0), 0x15 (slot 1), 0x18 (slot 3) and 0x34 (slot 5). An absent slot records no events and raises no interrupt. Any unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| e3_mode | input | 1 | 0 selects the DS3 map, 1 selects the E3 map |
| evt_i | input | 6*SRC_W | Event pulses. Slot s occupies bits [s*SRC_W +: SRC_W] |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid one cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can collide in one cycle: a new enabled event arriving on the same edge as the read that clears its status register. The bench provokes this by raising the event bits while the read strobe of that register is high. It judges the outcome by the value the read returns, which must be the old bits, and by a second read, which must return the new bits. A sweep over every enable and event pattern in each mapped slot of both modes checks the latch, the clear, the summary and the interrupt pin. A separate sequence of repeated service reads checks the trip point, the flag and re-arming.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int NSLOT = 6;
    localparam int NRX   = 4;

    localparam logic [7:0] ADDR_SUMMARY = 8'h10;
    localparam logic [7:0] ADDR_STORM   = 8'h12;
    localparam logic [7:0] ENABLE_OFS   = 8'h40;

    // status address of a slot under the selected map
    function automatic logic [7:0] slot_addr(input int s, input logic e3);
        case (s)
            0:       return e3 ? 8'h14 : 8'h13;
            1:       return 8'h15;
            2:       return 8'h17;
            3:       return 8'h18;
            4:       return 8'h31;
            default: return 8'h34;
        endcase
    endfunction

    // whether a slot exists under the selected map
    function automatic logic slot_live(input int s, input logic e3);
        case (s)
            1:       return e3;
            2, 4:    return !e3;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_hub_pkg::*;
(
    input  logic [7:0]       addr,
    input  logic             e3_mode,
    output logic [NSLOT-1:0] live,
    output logic [NSLOT-1:0] sel_status,
    output logic [NSLOT-1:0] sel_enable,
    output logic             sel_summary,
    output logic             sel_storm
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_dec
        assign live[s]       = slot_live(s, e3_mode);
        assign sel_status[s] = live[s] && (addr == slot_addr(s, e3_mode));
        assign sel_enable[s] = live[s] && (addr == slot_addr(s, e3_mode) + ENABLE_OFS);
    end

    assign sel_summary = (addr == ADDR_SUMMARY);
    assign sel_storm   = (addr == ADDR_STORM);

endmodule

// File: rtl/irq_storm_fsm.sv
module irq_storm_fsm #(
    parameter int STORM_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic service,
    input  logic quiet,
    input  logic rearm,
    output logic trip,
    output logic tripped
);

    localparam int CW = (STORM_N < 2) ? 1 : $clog2(STORM_N);
    localparam logic [CW-1:0] LAST = CW'(STORM_N - 1);

    typedef enum logic [1:0] {
        S_QUIET    = 2'd0,
        S_COUNTING = 2'd1,
        S_TRIPPED  = 2'd2
    } guard_state_t;

    guard_state_t   state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_QUIET;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            S_QUIET: begin
                if (service) begin
                    if (cnt == LAST) begin
                        state_nx = S_TRIPPED;
                        cnt_nx   = '0;
                    end else begin
                        state_nx = S_COUNTING;
                        cnt_nx   = cnt + 1'b1;
                    end
                end
            end
            S_COUNTING: begin
                if (service) begin
                    if (cnt == LAST) begin
                        state_nx = S_TRIPPED;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx   = cnt + 1'b1;
                    end
                end else if (quiet) begin
                    state_nx = S_QUIET;
                    cnt_nx   = '0;
                end
            end
            S_TRIPPED: begin
                if (rearm) begin
                    state_nx = S_QUIET;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = S_QUIET;
                cnt_nx   = '0;
            end
        endcase
    end

    always_comb begin
        trip    = (state != S_TRIPPED) && service && (cnt == LAST);
        tripped = (state == S_TRIPPED);
    end

    assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    assert_trip_enters_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> (state == S_TRIPPED));

    assert_quiet_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COUNTING && quiet && !service) |=> (state == S_QUIET && cnt == '0));

endmodule

// File: rtl/irq_slot.sv
module irq_slot #(
    parameter int SRC_W   = 4,
    parameter int STORM_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             live,
    input  logic [SRC_W-1:0] evt,
    input  logic             rd_status,
    input  logic             wr_enable,
    input  logic [SRC_W-1:0] wr_bits,
    output logic [SRC_W-1:0] status,
    output logic [SRC_W-1:0] enable,
    output logic             trip
);

    logic             tripped;
    logic [SRC_W-1:0] captured;
    logic             service, quiet;

    assign captured = live ? (evt & enable) : '0;
    assign service  = rd_status && (status != '0);
    assign quiet    = rd_status && (status == '0);

    irq_storm_fsm #(.STORM_N(STORM_N)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .service (service),
        .quiet   (quiet),
        .rearm   (wr_enable),
        .trip    (trip),
        .tripped (tripped)
    );

    // new events take priority over the read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            status <= '0;
        else if (!live)
            status <= '0;
        else
            status <= (rd_status ? '0 : status) | captured;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            enable <= '0;
        else if (trip)
            enable <= '0;
        else if (wr_enable)
            enable <= wr_bits;
    end

    assert_set_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status)) & ~$past(evt & enable)) == '0);

    assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && live) |=> (status == $past(evt & enable)));

    assert_event_survives_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && rd_status && (captured != '0)) |=> ((status & $past(captured)) == $past(captured)));

    assert_guard_holds_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> (enable == '0));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int SRC_W   = 4,
    parameter int STORM_N = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   e3_mode,
    input  logic [NSLOT*SRC_W-1:0] evt_i,
    input  logic                   rd_en,
    input  logic                   wr_en,
    input  logic [7:0]             addr,
    input  logic [7:0]             wr_data,
    output logic [7:0]             rd_data,
    output logic                   irq_n
);

    localparam int DW = 8;

    logic [NSLOT-1:0] live, sel_status, sel_enable;
    logic             sel_summary, sel_storm;
    logic [NSLOT-1:0] trip;
    logic [NSLOT-1:0] storm_flag;
    logic [SRC_W-1:0] st  [NSLOT];
    logic [SRC_W-1:0] en  [NSLOT];
    logic             rx_pend, tx_pend;
    logic [DW-1:0]    rd_mux;

    irq_addr_dec u_dec (
        .addr        (addr),
        .e3_mode     (e3_mode),
        .live        (live),
        .sel_status  (sel_status),
        .sel_enable  (sel_enable),
        .sel_summary (sel_summary),
        .sel_storm   (sel_storm)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        irq_slot #(.SRC_W(SRC_W), .STORM_N(STORM_N)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .live      (live[s]),
            .evt       (evt_i[s*SRC_W +: SRC_W]),
            .rd_status (rd_en && sel_status[s]),
            .wr_enable (wr_en && sel_enable[s]),
            .wr_bits   (wr_data[SRC_W-1:0]),
            .status    (st[s]),
            .enable    (en[s]),
            .trip      (trip[s])
        );
    end

    always_comb begin
        rx_pend = 1'b0;
        tx_pend = 1'b0;
        for (int s = 0; s < NSLOT; s++) begin
            if (s < NRX) rx_pend = rx_pend | (|st[s]);
            else         tx_pend = tx_pend | (|st[s]);
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (sel_status[s]) rd_mux[SRC_W-1:0] = rd_mux[SRC_W-1:0] | st[s];
            if (sel_enable[s]) rd_mux[SRC_W-1:0] = rd_mux[SRC_W-1:0] | en[s];
        end
        if (sel_summary) rd_mux[1:0]       = {tx_pend, rx_pend};
        if (sel_storm)   rd_mux[NSLOT-1:0] = storm_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    // a trip on the same edge as a flag read stays recorded
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            storm_flag <= '0;
        else
            storm_flag <= ((rd_en && sel_storm) ? '0 : storm_flag) | trip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= !(rx_pend || tx_pend);
    end

    assert_irq_low_when_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pend || tx_pend) |=> !irq_n);

    assert_irq_high_when_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_pend || tx_pend) |=> irq_n);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip != '0) |=> ((storm_flag & $past(trip)) == $past(trip)));

    assert_one_slot_per_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_status));

endmodule

// File: tb/tb_irq_hub.sv
`timescale 1ns/1ps
module tb_irq_hub;

    localparam int SRC_W = 4;
    localparam int NS    = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              e3_mode = 1'b0;
    logic [NS*SRC_W-1:0] evt_i = '0;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        addr = '0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rd_data;
    logic              irq_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_hub #(.SRC_W(SRC_W), .STORM_N(4)) dut (
        .clk(clk), .rst_n(rst_n), .e3_mode(e3_mode), .evt_i(evt_i),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // bench-side address map (R9, R10)
    function automatic logic [7:0] map_addr(input int s, input bit e3);
        logic [7:0] a [NS];
        a[0] = e3 ? 8'h14 : 8'h13; a[1] = 8'h15; a[2] = 8'h17;
        a[3] = 8'h18; a[4] = 8'h31; a[5] = 8'h34;
        return a[s];
    endfunction

    function automatic bit map_live(input int s, input bit e3);
        if (s == 1) return e3;
        if (s == 2 || s == 4) return !e3;
        return 1'b1;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic pulse(input int s, input logic [SRC_W-1:0] v);
        @(negedge clk); evt_i[s*SRC_W +: SRC_W] = v;
        @(negedge clk); evt_i = '0;
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 rd_data", rd_data, 8'h00);
        rst_n = 1'b1;
        rd(8'h10, d); chk("R1 summary", d, 8'h00);
        rd(8'h12, d); chk("R1 storm flags", d, 8'h00);
        for (int s = 0; s < NS; s++) begin
            if (map_live(s, 1'b0)) begin
                rd(map_addr(s, 1'b0), d);         chk("R1 status", d, 8'h00);
                rd(map_addr(s, 1'b0) + 8'h40, d); chk("R1 enable", d, 8'h00);
            end
        end

        // sweep: both maps, every slot, every enable/event pattern
        for (int m = 0; m < 2; m++) begin
            e3_mode = m[0];
            for (int s = 0; s < NS; s++) begin
                if (!map_live(s, m[0])) begin
                    // absent slot: events vanish, its address reads 0 (R10)
                    pulse(s, 4'hF);
                    @(negedge clk);
                    chk("R10 absent slot irq", {7'd0, irq_n}, 8'h01);
                    rd(map_addr(s, m[0]), d);
                    chk("R10 absent slot read", d, 8'h00);
                    rd(8'h10, d);
                    chk("R10 absent slot summary", d, 8'h00);
                    continue;
                end
                for (int en = 0; en < 16; en++) begin
                    wr(map_addr(s, m[0]) + 8'h40, 8'(en));
                    rd(map_addr(s, m[0]) + 8'h40, d);
                    chk("R7 enable readback", d, 8'(en));
                    for (int ev = 0; ev < 16; ev++) begin
                        logic [7:0] exp_st;
                        exp_st = 8'(en & ev);
                        pulse(s, 4'(ev));
                        @(negedge clk);
                        chk("R6 irq after event", {7'd0, irq_n}, {7'd0, exp_st == 0});
                        rd(8'h10, d);
                        chk("R5 summary", d, (exp_st == 0) ? 8'h00 : ((s < 4) ? 8'h01 : 8'h02));
                        rd(map_addr(s, m[0]), d);
                        chk(m[0] ? "R2 R10 status latch" : "R2 R9 status latch", d, exp_st);
                        rd(map_addr(s, m[0]), d);
                        chk("R3 status cleared", d, 8'h00);
                        chk("R6 irq released", {7'd0, irq_n}, 8'h01);
                    end
                end
                wr(map_addr(s, m[0]) + 8'h40, 8'h00);
            end
        end
        rd(8'h12, d); chk("R8 no trip during sweep", d, 8'h00);

        // unmapped addresses (R10)
        e3_mode = 1'b1;
        rd(8'h13, d); chk("R10 DS3 address unmapped in E3", d, 8'h00);
        rd(8'h57, d); chk("R10 enable unmapped in E3", d, 8'h00);
        e3_mode = 1'b0;
        rd(8'h15, d); chk("R10 E3 address unmapped in DS3", d, 8'h00);

        // same-edge event and read-clear (R4)
        wr(8'h74, 8'h0F);
        pulse(5, 4'h3);
        @(negedge clk); rd_en = 1'b1; addr = 8'h34; evt_i[5*SRC_W +: SRC_W] = 4'hC;
        @(negedge clk); rd_en = 1'b0; evt_i = '0;
        chk("R4 read returns old bits", rd_data, 8'h03);
        rd(8'h34, d); chk("R4 new bits kept", d, 8'h0C);
        rd(8'h34, d); chk("R4 then clear", d, 8'h00);

        // summary clears only after last receive slot is read (R5)
        wr(8'h53, 8'h0F); wr(8'h58, 8'h0F);
        pulse(0, 4'h1); pulse(3, 4'h2);
        rd(8'h10, d); chk("R5 rx pending", d, 8'h01);
        rd(8'h13, d); chk("R5 slot0 read", d, 8'h01);
        rd(8'h10, d); chk("R5 rx still pending", d, 8'h01);
        rd(8'h18, d); chk("R5 slot3 read", d, 8'h02);
        rd(8'h10, d); chk("R5 rx cleared", d, 8'h00);
        rd(8'h13, d); rd(8'h18, d);

        // recurring fault re-raises irq (R6)
        pulse(0, 4'h4); rd(8'h13, d);
        @(negedge clk);
        chk("R6 irq high after service", {7'd0, irq_n}, 8'h01);
        pulse(0, 4'h4);
        @(negedge clk);
        chk("R6 irq low on recurrence", {7'd0, irq_n}, 8'h00);
        rd(8'h13, d); rd(8'h13, d);

        // quiet read restarts the storm count (R8)
        for (int i = 0; i < 3; i++) begin pulse(3, 4'h1); rd(8'h18, d); end
        rd(8'h18, d);
        for (int i = 0; i < 3; i++) begin pulse(3, 4'h1); rd(8'h18, d); end
        rd(8'h58, d); chk("R8 enable survives after quiet read", d, 8'h0F);
        rd(8'h18, d);

        // four consecutive services trip slot 3 (R8)
        for (int i = 0; i < 3; i++) begin pulse(3, 4'h1); rd(8'h18, d); end
        rd(8'h58, d); chk("R8 enable before trip", d, 8'h0F);
        pulse(3, 4'h1); rd(8'h18, d);
        rd(8'h58, d); chk("R8 enable cleared by trip", d, 8'h00);
        rd(8'h12, d); chk("R8 storm flag", d, 8'h08);
        rd(8'h12, d); chk("R8 storm flag cleared", d, 8'h00);
        pulse(3, 4'hF);
        @(negedge clk);
        chk("R8 tripped slot silent irq", {7'd0, irq_n}, 8'h01);
        rd(8'h18, d); chk("R8 tripped slot silent status", d, 8'h00);
        wr(8'h58, 8'h0F);
        pulse(3, 4'h2);
        rd(8'h18, d); chk("R8 re-armed slot latches", d, 8'h02);
        rd(8'h18, d);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule